// File: doc/BRIEF.md
# Hybrid Redundancy Spare Switch

This block protects one registered datapath word by running five copies of the producing logic side by side. Three copies are voted and two wait as powered standby spares. Every copy's word enters the block on each beat. The block keeps one health flag per copy and routes the three lowest-indexed healthy copies to the three voter positions. A bitwise two-out-of-three vote over those positions gives the protected word.

Every copy, spares included, is compared with the voted word on each accepted beat. A copy that differs in any bit loses its health flag for good, until the next reset. The routing is produced by a ripple chain of identical counting cells, one per copy. Each cell passes a saturating count of the healthy copies to its left, and the chain follows a rotary switching order. When fewer than three copies stay healthy, the block raises a failure flag and the empty voter positions read as zero.

The word stream uses valid/ready. The block holds no storage on the data path: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. A beat counts as accepted only when `in_valid` and `out_ready` are both high. Health flags change only on accepted beats, so the upstream and downstream sides can stall freely without a stalled beat being judged.

Top module: `hybrid_spare_switch`

## Requirements
- R1: While `rst_n` is low and right after it is released, every bit of `health` is 1 and `sys_fail` is 0.
- R2: Copy index 0 is the leftmost cell. Voter positions 1, 2 and 3 take the first, second and third healthy copies by ascending index. With copy 2 unhealthy the voted set is {0,1,3}. If copy 1 then also fails, the set becomes {0,3,4}.
- R3: `out_data` is the bitwise majority of the words in the three voter positions. It is combinational in the current `mod_data` and `health`.
- R4: On an accepted beat, a copy whose word differs from `out_data` in any bit has its `health` bit cleared at that clock edge. The change takes effect on the next beat.
- R5: A cleared `health` bit stays 0 until reset, even when that copy agrees again on later beats.
- R6: Spare copies that are not in the voted set are also compared with `out_data`, and they lose health on disagreement the same way voted copies do.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. `health` does not change on a clock edge unless `in_valid` and `out_ready` were both 1.
- R8: `sys_fail` is 1 exactly when fewer than three `health` bits are 1. An unfilled voter position contributes zero, so with two healthy copies `out_data` is the bitwise AND of their words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | All copy words on `mod_data` are valid |
| in_ready | output | 1 | Beat can be taken (follows `out_ready`) |
| mod_data | input | NUM_MOD*DATA_W | Copy words, copy i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Voted word valid (follows `in_valid`) |
| out_ready | input | 1 | Downstream takes the voted word |
| out_data | output | DATA_W | Voted word |
| health | output | NUM_MOD | Per-copy health flags, 1 = never disagreed |
| sys_fail | output | 1 | Fewer than three healthy copies remain |

## Verification
Random beats alternate between clean beats, one corrupted copy, and two copies corrupted in different bits. A single corruption checks that the vote masks the fault and that the right flag drops. A double corruption tells a correct routing map from a wrong one, because the outcome depends on which copies are actually voted. Stalled beats carry disagreeing words to show that nothing is judged without the handshake. Directed sequences walk the rotary reassignment through the {0,1,3} and {0,3,4} sets, reach the failure state with two copies left, and corrupt an unvoted spare.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int unsigned CORE_N = 3;

  typedef logic [CORE_N-1:0] carry_t;

  function automatic logic majority_bit(input logic [CORE_N-1:0] votes);
    int unsigned ones;
    ones = 0;
    for (int k = 0; k < CORE_N; k++) ones += votes[k];
    return (ones > (CORE_N / 2));
  endfunction
endpackage

// File: rtl/hrs_cell.sv
module hrs_cell
  import hrs_pkg::*;
(
  input  logic   healthy,
  input  carry_t carry_in,
  output carry_t carry_out,
  output carry_t sel
);
  // one-hot count of healthy copies to the left; all-zero means saturated
  always_comb begin
    sel       = healthy ? carry_in : '0;
    carry_out = healthy ? {carry_in[CORE_N-2:0], 1'b0} : carry_in;
  end
endmodule

// File: rtl/hrs_chain.sv
module hrs_chain
  import hrs_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5
) (
  input  logic [NUM_MOD-1:0]             healthy,
  output logic [NUM_MOD-1:0][CORE_N-1:0] sel,
  output logic                           saturated
);
  carry_t link [NUM_MOD+1];

  assign link[0] = carry_t'(1);

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_cell
    hrs_cell u_cell (
      .healthy  (healthy[i]),
      .carry_in (link[i]),
      .carry_out(link[i+1]),
      .sel      (sel[i])
    );
  end

  assign saturated = (link[NUM_MOD] == '0);
endmodule

// File: rtl/hrs_vote.sv
module hrs_vote
  import hrs_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic [NUM_MOD-1:0][DATA_W-1:0] words,
  input  logic [NUM_MOD-1:0][CORE_N-1:0] sel,
  output logic [DATA_W-1:0]              voted
);
  logic [CORE_N-1:0][DATA_W-1:0] pos_word;

  // AND/OR interconnection: each voter position gathers its selected copy
  always_comb begin
    for (int j = 0; j < CORE_N; j++) begin
      pos_word[j] = '0;
      for (int i = 0; i < NUM_MOD; i++)
        pos_word[j] = pos_word[j] | (words[i] & {DATA_W{sel[i][j]}});
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [CORE_N-1:0] column;
    always_comb begin
      for (int j = 0; j < CORE_N; j++) column[j] = pos_word[j][b];
    end
    assign voted[b] = majority_bit(column);
  end
endmodule

// File: rtl/hrs_condition.sv
module hrs_condition #(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept,
  input  logic [NUM_MOD-1:0][DATA_W-1:0] words,
  input  logic [DATA_W-1:0]              voted,
  output logic [NUM_MOD-1:0]             healthy
);
  logic [NUM_MOD-1:0] mismatch;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_cmp
    assign mismatch[i] = |(words[i] ^ voted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      healthy <= '1;
    else if (accept) healthy <= healthy & ~mismatch;
  end
endmodule

// File: rtl/hybrid_spare_switch.sv
module hybrid_spare_switch
  import hrs_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_MOD*DATA_W-1:0]   mod_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_data,
  output logic [NUM_MOD-1:0]          health,
  output logic                        sys_fail
);
  localparam int unsigned SPARES = NUM_MOD - CORE_N;

  logic [NUM_MOD-1:0][DATA_W-1:0] words;
  logic [NUM_MOD-1:0][CORE_N-1:0] sel;
  logic                           saturated;
  logic                           accept;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_unpack
    assign words[i] = mod_data[i*DATA_W +: DATA_W];
  end

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign accept    = in_valid & out_ready;

  hrs_chain #(.NUM_MOD(NUM_MOD)) u_chain (
    .healthy  (health),
    .sel      (sel),
    .saturated(saturated)
  );

  hrs_vote #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W)) u_vote (
    .words(words),
    .sel  (sel),
    .voted(out_data)
  );

  hrs_condition #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .words  (words),
    .voted  (out_data),
    .healthy(health)
  );

  assign sys_fail = (SPARES >= 0) ? ~saturated : 1'b1;
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      out_ready,
  input logic [NUM_MOD*DATA_W-1:0] mod_data,
  input logic [DATA_W-1:0]         out_data,
  input logic [NUM_MOD-1:0]        health,
  input logic                      sys_fail
);
  // R5
  sticky_health_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((health & ~$past(health)) == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |=> $stable(health));

  // R8
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fail == ($countones(health) < 3));

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_drop
    // R4
    drop_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && out_ready && (mod_data[i*DATA_W +: DATA_W] != out_data)) |=> !health[i]);
  end
endmodule

bind hybrid_spare_switch hrs_checker #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W)) u_hrs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_ready(out_ready),
  .mod_data (mod_data),
  .out_data (out_data),
  .health   (health),
  .sys_fail (sys_fail)
);

// File: tb/hybrid_spare_switch_tb_top.sv
module hybrid_spare_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 5;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [NM-1:0][W-1:0] words = '0;
  logic in_ready, out_valid, sys_fail;
  logic [W-1:0] out_data;
  logic [NM-1:0] health;
  logic [NM-1:0] m_health;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_spare_switch #(.NUM_MOD(NM), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mod_data(words), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .health(health), .sys_fail(sys_fail)
  );

  function automatic logic [W-1:0] exp_vote(input logic [NM-1:0][W-1:0] w, input logic [NM-1:0] h);
    logic [2:0][W-1:0] pos;
    int cnt;
    pos = '0;
    cnt = 0;
    for (int i = 0; i < NM; i++)
      if (h[i] && cnt < 3) begin pos[cnt] = w[i]; cnt++; end
    return (pos[0] & pos[1]) | (pos[0] & pos[2]) | (pos[1] & pos[2]);
  endfunction

  function automatic int ones(input logic [NM-1:0] h);
    int c = 0;
    for (int i = 0; i < NM; i++) c += h[i];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 health in reset", health, 5'h1f);
    @(negedge clk);
    rst_n = 1'b1;
    m_health = '1;
    #1;
    check("R1 health after reset", health, 5'h1f);
    check("R1 sys_fail after reset", sys_fail, 0);
  endtask

  task automatic beat(input logic [NM-1:0][W-1:0] w, input logic v, input logic r,
                      output logic [W-1:0] seen);
    logic [W-1:0] ev;
    @(negedge clk);
    words = w; in_valid = v; out_ready = r;
    #1;
    ev = exp_vote(w, m_health);
    seen = out_data;
    check("R3 voted word", out_data, ev);
    check("R4 health", health, m_health);
    check("R8 sys_fail", sys_fail, ones(m_health) < 3);
    check("R7 out_valid", out_valid, v);
    check("R7 in_ready", in_ready, r);
    @(posedge clk);
    if (v && r)
      for (int i = 0; i < NM; i++) if (w[i] != ev) m_health[i] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [NM-1:0][W-1:0] w;
    logic [W-1:0] seen;
    logic [W-1:0] a, b;
    void'($urandom(32'd2024));
    m_health = '1;
    do_reset();

    // R6: unvoted spare 4 disagrees while all are healthy
    a = 8'h5a;
    w = {NM{a}}; w[4] = 8'ha5;
    beat(w, 1, 1, seen);
    check("R6 spare output masked", seen, a);
    w = {NM{a}};
    beat(w, 1, 1, seen);
    check("R6 spare flag cleared", health, 5'h0f);

    // R5: copy 4 agrees again but stays unhealthy
    repeat (3) beat(w, 1, 1, seen);
    check("R5 sticky flag", health, 5'h0f);

    // R2 walk: fail copy 2, then 1
    do_reset();
    a = 8'h3c; b = 8'hc3;
    w = {NM{a}}; w[2] = b;
    beat(w, 1, 1, seen);
    w[0] = a; w[1] = b; w[2] = b; w[3] = a; w[4] = b;
    beat(w, 1, 0, seen);
    check("R2 set {0,1,3}", seen, a);
    check("R7 stall keeps health", health, 5'h1b);
    w = {NM{a}}; w[1] = b;
    beat(w, 1, 1, seen);
    w[0] = a; w[1] = a; w[2] = a; w[3] = b; w[4] = b;
    beat(w, 1, 0, seen);
    check("R2 set {0,3,4}", seen, b);
    check("R8 three healthy", sys_fail, 0);
    w = {NM{a}}; w[0] = b;
    beat(w, 1, 1, seen);
    w[0] = 8'hff; w[1] = 8'hff; w[2] = 8'hff; w[3] = 8'hf0; w[4] = 8'h3c;
    beat(w, 0, 1, seen);
    check("R8 two left AND", seen, 8'h30);
    check("R8 fail flag", sys_fail, 1);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int r, k1, k2;
      if (n % 60 == 0) do_reset();
      a = W'($urandom);
      w = {NM{a}};
      r = $urandom % 8;
      k1 = $urandom % NM;
      k2 = (k1 + 1 + ($urandom % (NM - 1))) % NM;
      if (r < 2) w[k1] = a ^ W'(1 << ($urandom % W));
      else if (r == 2) begin
        w[k1] = a ^ 8'h0f;
        w[k2] = a ^ 8'hf0;
      end
      beat(w, ($urandom % 8) != 0, ($urandom % 8) != 0, seen);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule